// File: doc/BRIEF.md
# Power-up configuration selection controller

This block picks how a clock generator comes up once power-on reset is released. On the first clock after release it latches a mode strap. A low strap selects software mode: the serial register port is opened and the select pins play no further part. A high strap selects hardware select mode: the serial port stays closed, and the two select pins pick one of four stored configuration words.

In both modes the block reports the chosen set as a 2-bit index, together with the stored word for that index and a one-cycle load strobe. In hardware select mode it watches the select pins for the rest of operation. It ignores them during a startup window. After that window, a change that has settled on one pin reloads the new set, and a change on both pins at once is refused and flagged. Every load holds a busy output high for a settle period. Both intervals are given in microseconds and scaled by a cycles-per-microsecond parameter.

Top module: `cfg_select_ctrl`

## Requirements
- R1: The strap is taken once, in the first cycle after por_n rises. A low strap sets sw_access to 1 and a high strap sets it to 0. Later strap changes leave sw_access unchanged until the next reset.
- R2: With the strap high, the first cycle after release pulses cfg_load for exactly one cycle. cfg_idx is set to {sel[1], sel[0]} as a binary value, and cfg_word shows stored word cfg_idx (bits cfg_idx*CFG_W upward of CFG_TABLE).
- R3: With the strap low, dflt_keep is read at release. When dflt_keep is 0, cfg_load pulses with cfg_idx 0. When dflt_keep is 1, no load occurs, cfg_idx stays 0 and busy stays low.
- R4: In software mode the select pins never cause a load, and cfg_idx stays 0.
- R5: Select pin changes during the first STARTUP_US*CYC_PER_US cycles after release cause no load. Values seen in that window become the new reference, so no load follows when the window ends.
- R6: After the window, a change of one select bit that has been steady for STABLE_CYC cycles past the two-flop synchroniser pulses cfg_load once and sets cfg_idx to the new value.
- R7: A settled change that flips both bits relative to the reference sets sel_violation. It gives no load and leaves cfg_idx unchanged. The next accepted single-bit change loads normally and clears sel_violation.
- R8: busy is high for SETTLE_US*CYC_PER_US cycles starting with each load strobe. A change made while busy is high is held back and acted on once busy falls.
- R9: A select pulse shorter than STABLE_CYC cycles that returns to the reference value causes no load.
- R10: While por_n is low, cfg_idx, cfg_load, sw_access, busy and sel_violation are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| mode_strap | input | 1 | Mode strap: 0 software mode, 1 hardware select mode |
| sel | input | 2 | Configuration select pins, sel[1] is the high bit |
| dflt_keep | input | 1 | Stored load-enable bit used in software mode |
| cfg_idx | output | 2 | Index of the active configuration set |
| cfg_load | output | 1 | One-cycle strobe to load set cfg_idx |
| cfg_word | output | CFG_W | Stored configuration word for cfg_idx |
| sw_access | output | 1 | Serial register access enabled |
| busy | output | 1 | Configuration load settling |
| sel_violation | output | 1 | Both select bits changed together |

## Verification
The bench targets the edges of the startup window. A change made inside the window must be absorbed and must not fire when the window opens; a design that defers it instead would load a set nobody asked for at 10 ms. It also drives a short glitch and a two-bit flip. The glitch catches a missing stability filter, which would reload on noise. The flip catches a design that loads one of the two bits or leaves the flag set. Finally, it changes a pin while busy is high and expects the load exactly when busy falls, which exposes a design that drops the change or cuts the settle period short.

// File: rtl/cfg_select_ctrl.sv
module cfg_select_ctrl #(
  parameter int CYC_PER_US = 125,
  parameter int STARTUP_US = 10000,
  parameter int SETTLE_US  = 1000,
  parameter int STABLE_CYC = 4,
  parameter int CFG_W      = 8,
  parameter logic [4*CFG_W-1:0] CFG_TABLE = 32'hD3A27140
)(
  input  logic             clk,
  input  logic             por_n,
  input  logic             mode_strap,
  input  logic [1:0]       sel,
  input  logic             dflt_keep,
  output logic [1:0]       cfg_idx,
  output logic             cfg_load,
  output logic [CFG_W-1:0] cfg_word,
  output logic             sw_access,
  output logic             busy,
  output logic             sel_violation
);
  localparam int STARTUP_CYC = CYC_PER_US * STARTUP_US;
  localparam int SETTLE_CYC  = CYC_PER_US * SETTLE_US;
  localparam int TW = $clog2(STARTUP_CYC + 1);
  localparam int BW = $clog2(SETTLE_CYC + 1);
  localparam int KW = $clog2(STABLE_CYC + 1);

  logic [2:0]    s1, s2;
  logic          init_done, hw_mode;
  logic [TW-1:0] start_cnt;
  logic [BW-1:0] settle;
  logic [KW-1:0] stab;
  logic [1:0]    sel_ref;

  always_ff @(posedge clk) begin
    s1 <= {mode_strap, sel};
    s2 <= s1;
  end

  wire [1:0] sel_s       = s2[1:0];
  wire       window_open = start_cnt == TW'(STARTUP_CYC);
  wire       sel_steady  = stab == KW'(STABLE_CYC);
  wire       take        = hw_mode && window_open && !busy && sel_steady && (sel_s != sel_ref);
  wire       both_flip   = &(sel_s ^ sel_ref);

  assign busy     = settle != '0;
  assign cfg_word = CFG_TABLE[cfg_idx*CFG_W +: CFG_W];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      init_done     <= 1'b0;
      hw_mode       <= 1'b0;
      sw_access     <= 1'b0;
      start_cnt     <= '0;
      settle        <= '0;
      stab          <= '0;
      sel_ref       <= 2'd0;
      cfg_idx       <= 2'd0;
      cfg_load      <= 1'b0;
      sel_violation <= 1'b0;
    end else begin
      cfg_load <= 1'b0;
      if (s1[1:0] != s2[1:0]) stab <= '0;
      else if (!sel_steady)   stab <= stab + 1'b1;
      if (busy) settle <= settle - 1'b1;
      if (!init_done) begin
        init_done <= 1'b1;
        hw_mode   <= s2[2];
        sw_access <= !s2[2];
        sel_ref   <= sel_s;
        if (s2[2] || !dflt_keep) begin
          cfg_idx  <= s2[2] ? sel_s : 2'd0;
          cfg_load <= 1'b1;
          settle   <= BW'(SETTLE_CYC);
        end
      end else begin
        if (!window_open) start_cnt <= start_cnt + 1'b1;
        if (hw_mode && !window_open) begin
          sel_ref <= sel_s;
        end else if (take) begin
          sel_ref <= sel_s;
          if (both_flip) begin
            sel_violation <= 1'b1;
          end else begin
            cfg_idx       <= sel_s;
            cfg_load      <= 1'b1;
            settle        <= BW'(SETTLE_CYC);
            sel_violation <= 1'b0;
          end
        end
      end
    end
  end

  // R2
  load_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    cfg_load |=> !cfg_load);
  // R8
  load_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
    cfg_load |-> busy);
  // R4
  sw_idx_chk: assert property (@(posedge clk) disable iff (!por_n)
    sw_access |-> (cfg_idx == 2'd0));
  // R7
  viol_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sel_violation) |-> ($stable(cfg_idx) && !cfg_load));
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (init_done && $past(init_done)) |-> $stable(sw_access));
  // R6
  idx_change_chk: assert property (@(posedge clk) disable iff (!por_n)
    !cfg_load |-> $stable(cfg_idx));
endmodule

// File: tb/cfg_select_ctrl_test.sv
module cfg_select_ctrl_test;
  localparam int CPU = 1, STUP = 10000, SETL = 1000, STB = 3;
  localparam int STARTUP = CPU * STUP, SETTLE = CPU * SETL;

  logic clk = 1'b0, por_n = 1'b0, mode_strap = 1'b1, dflt_keep = 1'b0;
  logic [1:0] sel = 2'd2;
  logic [1:0] cfg_idx;
  logic cfg_load, sw_access, busy, sel_violation;
  logic [7:0] cfg_word;

  cfg_select_ctrl #(.CYC_PER_US(CPU), .STARTUP_US(STUP), .SETTLE_US(SETL),
    .STABLE_CYC(STB), .CFG_W(8), .CFG_TABLE(32'hD3A27140)) uut (
    .clk(clk), .por_n(por_n), .mode_strap(mode_strap), .sel(sel),
    .dflt_keep(dflt_keep), .cfg_idx(cfg_idx), .cfg_load(cfg_load),
    .cfg_word(cfg_word), .sw_access(sw_access), .busy(busy),
    .sel_violation(sel_violation));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R10";

  function automatic logic [7:0] word_of(input int i);
    case (i)
      0: return 8'h40;
      1: return 8'h71;
      2: return 8'hA2;
      default: return 8'hD3;
    endcase
  endfunction

  // behavioural reference
  int e = 0, k = 0, m_idx = 0, m_settle = 0, m_ref = 0;
  bit m_load = 0, m_sw = 0, m_hw = 0, m_viol = 0;
  int pq[$], sq[$], lq[$];

  always @(negedge por_n) begin
    k = 0; m_idx = 0; m_load = 0; m_sw = 0; m_hw = 0; m_viol = 0; m_settle = 0;
  end

  always @(posedge clk) begin
    int v, sv, lc;
    bit open, was_busy, steady;
    if (pq.size() == 0) lq.push_back(-1000000);
    else lq.push_back(int'(sel) != pq[$] ? e : lq[$]);
    pq.push_back(int'(sel));
    sq.push_back(int'(mode_strap));
    if (pq.size() >= 3) begin
      v = pq[pq.size()-3]; sv = sq[sq.size()-3]; lc = lq[lq.size()-3];
    end else begin
      v = pq[0]; sv = sq[0]; lc = -1000000;
    end
    steady = (e - 2 - lc) >= STB;
    if (!por_n) begin
      k = 0; m_idx = 0; m_load = 0; m_sw = 0; m_hw = 0; m_viol = 0; m_settle = 0;
    end else begin
      k++;
      m_load = 0;
      if (k == 1) begin
        m_hw = sv[0]; m_sw = !sv[0]; m_ref = v; m_viol = 0;
        if (sv[0] || !dflt_keep) begin
          m_idx = sv[0] ? v : 0; m_load = 1; m_settle = SETTLE;
        end
      end else begin
        open = (k - 2) >= STARTUP;
        was_busy = m_settle != 0;
        if (m_settle != 0) m_settle--;
        if (m_hw && !open) m_ref = v;
        else if (m_hw && !was_busy && steady && v != m_ref) begin
          if ((v ^ m_ref) == 3) m_viol = 1;
          else begin m_idx = v; m_load = 1; m_settle = SETTLE; m_viol = 0; end
          m_ref = v;
        end
      end
    end
    e++;
  end

  always @(posedge clk) begin
    #2;
    if (!done) begin
      total++;
      if (int'(cfg_idx) != m_idx || cfg_load != m_load || cfg_word != word_of(m_idx) ||
          sw_access != m_sw || busy != (m_settle != 0) || sel_violation != m_viol) begin
        bad++;
        $display("FAIL %s cycle %0d: idx=%0d load=%0b word=%h sw=%0b busy=%0b viol=%0b expected idx=%0d load=%0b word=%h sw=%0b busy=%0b viol=%0b",
          cur_req, k, cfg_idx, cfg_load, cfg_word, sw_access, busy, sel_violation,
          m_idx, m_load, word_of(m_idx), m_sw, (m_settle != 0), m_viol);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    cyc(5);
    // R2 hardware power-up with sel=2
    cur_req = "R2"; por_n = 1'b1;
    cyc(1);
    chk("R2 load", cfg_load, 1); chk("R2 idx", cfg_idx, 2);
    chk("R2 word", cfg_word, 8'hA2); chk("R1 sw hw", sw_access, 0);
    cyc(1);
    chk("R2 one cycle", cfg_load, 0);
    // R5 change inside startup window
    cur_req = "R5"; cyc(100); sel = 2'd0;
    cyc(10200);
    chk("R5 idx", cfg_idx, 2); chk("R5 busy", busy, 0);
    // R9 short glitch
    cur_req = "R9"; sel = 2'd1; cyc(2); sel = 2'd0; cyc(20);
    chk("R9 idx", cfg_idx, 2);
    // R6 single-bit change
    cur_req = "R6"; sel = 2'd1; cyc(10);
    chk("R6 idx", cfg_idx, 1); chk("R8 busy", busy, 1);
    mode_strap = 1'b0;
    // R8 change during busy is deferred
    cur_req = "R8"; cyc(5); sel = 2'd3; cyc(500);
    chk("R8 deferred", cfg_idx, 1);
    cyc(600);
    chk("R8 after busy", cfg_idx, 3);
    cyc(1100);
    // R7 two-bit flip
    cur_req = "R7"; sel = 2'd0; cyc(10);
    chk("R7 viol", sel_violation, 1); chk("R7 idx", cfg_idx, 3);
    sel = 2'd2; cyc(10);
    chk("R7 reload", cfg_idx, 2); chk("R7 clear", sel_violation, 0);
    chk("R1 strap ignored", sw_access, 0);
    cyc(1100);
    // R10 reset state
    cur_req = "R10"; por_n = 1'b0; mode_strap = 1'b0; dflt_keep = 1'b0; sel = 2'd3;
    cyc(1);
    chk("R10 idx", cfg_idx, 0); chk("R10 busy", busy, 0);
    chk("R10 sw", sw_access, 0); chk("R10 viol", sel_violation, 0);
    cyc(4);
    // R3 software mode, dflt_keep=0
    cur_req = "R3"; por_n = 1'b1; cyc(1);
    chk("R3 load", cfg_load, 1); chk("R3 idx", cfg_idx, 0); chk("R1 sw", sw_access, 1);
    // R4 pins ignored in software mode
    cur_req = "R4"; cyc(10500); sel = 2'd1; cyc(20); sel = 2'd2; cyc(20);
    chk("R4 idx", cfg_idx, 0); chk("R4 busy", busy, 0);
    // R3 software mode, dflt_keep=1
    cur_req = "R3"; por_n = 1'b0; dflt_keep = 1'b1; cyc(5);
    por_n = 1'b1; cyc(1);
    chk("R3 no load", cfg_load, 0); chk("R3 no busy", busy, 0); chk("R3 sw", sw_access, 1);
    cyc(20);
    // R2 hardware power-up with sel=3
    cur_req = "R2"; por_n = 1'b0; mode_strap = 1'b1; sel = 2'd3; cyc(5);
    por_n = 1'b1; cyc(1);
    chk("R2 idx3", cfg_idx, 3); chk("R2 word3", cfg_word, 8'hD3);
    cyc(5);
    finish_run();
  end
endmodule